// File: doc/BRIEF.md
# Packet Buffer Memory Manager

This block keeps track of a small pool of fixed-size packet buffers that a network controller's transmit and receive paths share. Software drives it with command words. One command asks for a buffer. One gives a numbered buffer back to the pool. One puts a buffer number on the transmit queue. One takes the oldest received buffer off the receive queue and frees it. One restores the whole manager to its starting state. Buffer numbers are also pushed in by the receive path, and the transmit path takes them off.

An allocation reports back through a result byte and an interrupt flag that software polls. If the pool is empty, the request is held. It completes on its own as soon as a buffer comes back. Two 16-bit status words are exposed. The memory word packs the number of free buffers with the pool size. The queue word shows whether each queue is empty and which buffer is at its head.

Top module: `pbm_mgr`

## Requirements
- R1: After `rst_n` is low, `alloc_result` is 0x00, `alloc_int` is 0, `mem_info` is 0x0404 and `fifo_status` is 0x8080 (default pool of 4).
- R2: A command word whose bits 7:5 are 001 (for example 0x0020), written while a buffer is free, sets `alloc_int` one clock later. In the same clock `alloc_result` bit 7 goes to 0 and bits 6:0 take the granted buffer number.
- R3: A grant always picks the lowest-numbered free buffer. From reset, four allocations return buffers 0, 1, 2 and 3 in that order.
- R4: `mem_info` bits 15:8 hold the current free count and bits 7:0 hold the pool size. It reads 0x0304, 0x0204, 0x0104 and 0x0004 after one, two, three and four grants.
- R5: Code 101 (0x00A0) frees the buffer named by the last `pnum_wdata` write, and the free count rises by one. Freeing a buffer that is already free leaves `mem_info` unchanged.
- R6: An allocation with no free buffer sets `alloc_result` bit 7 one clock later and leaves `alloc_int` low. The request stays pending. It completes in the clock after a buffer is freed: `alloc_int` rises and bits 6:0 take the freed number.
- R7: Code 110 (0x00C0) appends the last written packet number to the transmit queue. A pulse on `tx_taken` removes its head. A push to a queue that already holds `FIFO_DEPTH` entries is dropped.
- R8: In `fifo_status`, bit 15 is set when the receive queue is empty and bit 7 when the transmit queue is empty. Bits 14:8 hold the receive head, or 0 when that queue is empty. Bits 6:0 hold the transmit head, or `alloc_result` bits 6:0 when that queue is empty. After four grants with both queues empty it reads 0x8083.
- R9: `rx_done_we` appends `rx_done_num` to the receive queue. Code 100 (0x0080) removes the receive head and frees that buffer.
- R10: Code 010 (0x0040) frees every buffer, empties both queues, clears `alloc_int`, `alloc_result` and any pending allocation.
- R11: Codes 000, 011 and 111 in bits 7:5 change no output.
- R12: `int_ack` clears `alloc_int`. A grant in the same clock takes priority and leaves it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_we | input | 1 | Command word strobe |
| cmd_word | input | 16 | Command word; bits 7:5 select the operation |
| pnum_we | input | 1 | Packet-number register write strobe |
| pnum_wdata | input | 8 | Packet number used by release and enqueue |
| int_ack | input | 1 | Clears the allocation interrupt flag |
| rx_done_we | input | 1 | Receive path pushes a filled buffer number |
| rx_done_num | input | 8 | Buffer number pushed by the receive path |
| tx_taken | input | 1 | Transmit path removes the transmit queue head |
| alloc_result | output | 8 | Bit 7 failure flag, bits 6:0 buffer number |
| alloc_int | output | 1 | Allocation-complete interrupt flag |
| mem_info | output | 16 | Free count (15:8) and pool size (7:0) |
| fifo_status | output | 16 | Queue empty flags and head numbers |

## Verification
The case that is hardest to reach from the ports is a held allocation that finishes on its own. To get there, the bench empties the pool completely, issues one more allocation, and idles to show that nothing completes. It then frees one buffer and checks that the grant appears one clock later, even while `int_ack` is asserted in that same clock. A second path leaves an allocation pending and then issues the manager-reset command. The bench confirms the pending request is gone and does not complete against the restored pool. A third path overfills the transmit queue, drains it, and checks the head order and that the extra push was dropped.

// File: rtl/pbm_pkg.sv
package pbm_pkg;

   // Operation codes carried in bits 7:5 of the command word
   localparam logic [2:0] OPC_ALLOC   = 3'b001;
   localparam logic [2:0] OPC_RESET   = 3'b010;
   localparam logic [2:0] OPC_RX_FREE = 3'b100;
   localparam logic [2:0] OPC_FREE    = 3'b101;
   localparam logic [2:0] OPC_TX_PUSH = 3'b110;

   localparam int OPC_LSB = 5;

   // Width of a buffer index for a pool of n buffers (never below one bit)
   function automatic int idx_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/pbm_free_pool.sv
module pbm_free_pool
   import pbm_pkg::*;
#(
   parameter int NUM_BUFS = 4,
   localparam int IW = idx_width(NUM_BUFS),
   localparam int CW = $clog2(NUM_BUFS + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                clear_all,
   input  logic                grant_en,
   input  logic                rel_en,
   input  logic [IW-1:0]       rel_idx,
   output logic                any_free,
   output logic [IW-1:0]       grant_idx,
   output logic [CW-1:0]       free_cnt
);

   logic [NUM_BUFS-1:0] free_map;
   logic [NUM_BUFS-1:0] free_map_nxt;
   logic                rel_ok;

   // Lowest-numbered free buffer: scan downward so the smallest index wins
   always_comb begin
      grant_idx = '0;
      for (int i = NUM_BUFS - 1; i >= 0; i--) begin
         if (free_map[i]) grant_idx = IW'(i);
      end
   end

   assign any_free = |free_map;

   always_comb begin
      free_cnt = '0;
      for (int i = 0; i < NUM_BUFS; i++) begin
         free_cnt = free_cnt + CW'(free_map[i]);
      end
   end

   assign rel_ok = rel_en && (int'(rel_idx) < NUM_BUFS);

   always_comb begin
      free_map_nxt = free_map;
      if (clear_all) begin
         free_map_nxt = '1;
      end else begin
         if (rel_ok)   free_map_nxt[rel_idx]   = 1'b1;
         if (grant_en) free_map_nxt[grant_idx] = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) free_map <= '1;
      else        free_map <= free_map_nxt;
   end

   AST_GRANT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_en && !clear_all) |=> !free_map[$past(grant_idx)]); // R3

   AST_RELEASE_FREE: assert property (@(posedge clk) disable iff (!rst_n)
      (rel_ok && !clear_all && !(grant_en && grant_idx == rel_idx))
      |=> free_map[$past(rel_idx)]); // R5

   AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
      clear_all |=> (free_cnt == CW'(NUM_BUFS))); // R10

endmodule

// File: rtl/pbm_num_fifo.sv
module pbm_num_fifo #(
   parameter int DEPTH = 4,
   parameter int W     = 2,
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CW = $clog2(DEPTH + 1),
   localparam bit POW2 = (DEPTH == (1 << PW))
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic          push,
   input  logic [W-1:0]  push_data,
   input  logic          pop,
   output logic [W-1:0]  head,
   output logic          empty,
   output logic          full
);

   logic [W-1:0]  mem [DEPTH];
   logic [PW-1:0] rd_ptr;
   logic [PW-1:0] wr_ptr;
   logic [CW-1:0] count;
   logic          do_push;
   logic          do_pop;
   logic [PW-1:0] rd_ptr_inc;
   logic [PW-1:0] wr_ptr_inc;

   assign empty   = (count == '0);
   assign full    = (count == CW'(DEPTH));
   assign do_pop  = pop && !empty;
   assign do_push = push && (!full || do_pop);
   assign head    = mem[rd_ptr];

   // Pointer advance: free wrap for a power-of-two depth, explicit compare otherwise
   generate
      if (POW2) begin : g_wrap_free
         assign rd_ptr_inc = rd_ptr + 1'b1;
         assign wr_ptr_inc = wr_ptr + 1'b1;
      end else begin : g_wrap_cmp
         assign rd_ptr_inc = (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
         assign wr_ptr_inc = (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_ptr <= '0;
         wr_ptr <= '0;
         count  <= '0;
      end else if (flush) begin
         rd_ptr <= '0;
         wr_ptr <= '0;
         count  <= '0;
      end else begin
         if (do_pop)  rd_ptr <= rd_ptr_inc;
         if (do_push) wr_ptr <= wr_ptr_inc;
         if (do_push && !do_pop)      count <= count + 1'b1;
         else if (do_pop && !do_push) count <= count - 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (do_push) begin
         mem[wr_ptr] <= push_data;
      end
   end

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full && !pop && !flush) |=> (count == CW'(DEPTH))); // R7

   AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && empty && !push && !flush) |=> empty); // R7

   AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> empty); // R10

endmodule

// File: rtl/pbm_mgr.sv
module pbm_mgr
   import pbm_pkg::*;
#(
   parameter int NUM_BUFS   = 4,
   parameter int FIFO_DEPTH = NUM_BUFS
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cmd_we,
   input  logic [15:0] cmd_word,
   input  logic        pnum_we,
   input  logic [7:0]  pnum_wdata,
   input  logic        int_ack,
   input  logic        rx_done_we,
   input  logic [7:0]  rx_done_num,
   input  logic        tx_taken,
   output logic [7:0]  alloc_result,
   output logic        alloc_int,
   output logic [15:0] mem_info,
   output logic [15:0] fifo_status
);

   localparam int IW = idx_width(NUM_BUFS);
   localparam int CW = $clog2(NUM_BUFS + 1);

   generate
      if (NUM_BUFS < 2 || NUM_BUFS > 127) begin : g_bad_pool
         $error("pbm_mgr: NUM_BUFS must lie in 2..127");
      end
      if (FIFO_DEPTH < 1 || FIFO_DEPTH > 128) begin : g_bad_depth
         $error("pbm_mgr: FIFO_DEPTH must lie in 1..128");
      end
   endgenerate

   logic [2:0]    opc;
   logic          is_alloc, is_reset, is_rx_free, is_free, is_tx_push;
   logic [IW-1:0] pnum_q;
   logic          pend_q;
   logic          want, grant;
   logic          any_free;
   logic [IW-1:0] grant_idx;
   logic [CW-1:0] free_cnt;
   logic          rel_en;
   logic [IW-1:0] rel_idx;
   logic [IW-1:0] rx_head, tx_head;
   logic          rx_empty, rx_full, tx_empty, tx_full;
   logic          unused_bits;

   assign unused_bits = ^{cmd_word[15:8], cmd_word[4:0], pnum_wdata, rx_done_num,
                          rx_full, tx_full};

   // Command decode
   assign opc        = cmd_word[OPC_LSB +: 3];
   assign is_alloc   = cmd_we && (opc == OPC_ALLOC);
   assign is_reset   = cmd_we && (opc == OPC_RESET);
   assign is_rx_free = cmd_we && (opc == OPC_RX_FREE);
   assign is_free    = cmd_we && (opc == OPC_FREE);
   assign is_tx_push = cmd_we && (opc == OPC_TX_PUSH);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       pnum_q <= '0;
      else if (pnum_we) pnum_q <= pnum_wdata[IW-1:0];
   end

   // Allocation: a fresh request or a held one is granted when any buffer is free
   assign want  = is_alloc || pend_q;
   assign grant = want && any_free && !is_reset;

   assign rel_en  = is_free || (is_rx_free && !rx_empty);
   assign rel_idx = is_free ? pnum_q : rx_head;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q       <= 1'b0;
         alloc_result <= 8'h00;
         alloc_int    <= 1'b0;
      end else if (is_reset) begin
         pend_q       <= 1'b0;
         alloc_result <= 8'h00;
         alloc_int    <= 1'b0;
      end else begin
         if (grant) begin
            pend_q       <= 1'b0;
            alloc_result <= {1'b0, 7'(grant_idx)};
            alloc_int    <= 1'b1;
         end else begin
            if (is_alloc) begin
               pend_q          <= 1'b1;
               alloc_result[7] <= 1'b1;
            end
            if (int_ack) alloc_int <= 1'b0;
         end
      end
   end

   pbm_free_pool #(
      .NUM_BUFS (NUM_BUFS)
   ) u_pool (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear_all (is_reset),
      .grant_en  (grant),
      .rel_en    (rel_en),
      .rel_idx   (rel_idx),
      .any_free  (any_free),
      .grant_idx (grant_idx),
      .free_cnt  (free_cnt)
   );

   pbm_num_fifo #(
      .DEPTH (FIFO_DEPTH),
      .W     (IW)
   ) u_rx_q (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (is_reset),
      .push      (rx_done_we),
      .push_data (rx_done_num[IW-1:0]),
      .pop       (is_rx_free),
      .head      (rx_head),
      .empty     (rx_empty),
      .full      (rx_full)
   );

   pbm_num_fifo #(
      .DEPTH (FIFO_DEPTH),
      .W     (IW)
   ) u_tx_q (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (is_reset),
      .push      (is_tx_push),
      .push_data (pnum_q),
      .pop       (tx_taken),
      .head      (tx_head),
      .empty     (tx_empty),
      .full      (tx_full)
   );

   assign mem_info    = {8'(free_cnt), 8'(NUM_BUFS)};
   assign fifo_status = {rx_empty, rx_empty ? 7'd0 : 7'(rx_head),
                         tx_empty, tx_empty ? alloc_result[6:0] : 7'(tx_head)};

   AST_ALLOC_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      (is_alloc && any_free) |=> (alloc_int && !alloc_result[7])); // R2

   AST_ALLOC_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
      (is_alloc && !any_free) |=> (alloc_result[7] && pend_q)); // R6

   AST_RESET_CMD: assert property (@(posedge clk) disable iff (!rst_n)
      is_reset |=> (!alloc_int && !pend_q && alloc_result == 8'h00)); // R10

   AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (int_ack && !grant) |=> !alloc_int); // R12

endmodule

// File: tb/pbm_mgr_bench.sv
module pbm_mgr_bench;

   localparam int OP_CMD  = 1;
   localparam int OP_PNUM = 2;
   localparam int OP_RXD  = 3;
   localparam int OP_TXP  = 4;
   localparam int OP_ACK  = 5;
   localparam int NV      = 33;

   // {req[3:0], op[3:0], arg[15:0], res[7:0], irq, mem[15:0], fifo[15:0]}
   typedef logic [64:0] vec_t;
   localparam vec_t VEC [NV] = '{
      {4'd2,  4'd1, 16'h0020, 8'h00, 1'b1, 16'h0304, 16'h8080}, // R2 first grant
      {4'd12, 4'd5, 16'h0000, 8'h00, 1'b0, 16'h0304, 16'h8080}, // R12 ack
      {4'd3,  4'd1, 16'h0020, 8'h01, 1'b1, 16'h0204, 16'h8081}, // R3
      {4'd4,  4'd1, 16'h0020, 8'h02, 1'b1, 16'h0104, 16'h8082}, // R4
      {4'd8,  4'd1, 16'h0020, 8'h03, 1'b1, 16'h0004, 16'h8083}, // R8 0x8083
      {4'd12, 4'd5, 16'h0000, 8'h03, 1'b0, 16'h0004, 16'h8083}, // R12
      {4'd6,  4'd1, 16'h0020, 8'h83, 1'b0, 16'h0004, 16'h8083}, // R6 fail flag
      {4'd6,  4'd2, 16'h0002, 8'h83, 1'b0, 16'h0004, 16'h8083}, // R6 still held
      {4'd5,  4'd1, 16'h00A0, 8'h83, 1'b0, 16'h0104, 16'h8083}, // R5 free 2
      {4'd6,  4'd5, 16'h0000, 8'h02, 1'b1, 16'h0004, 16'h8082}, // R6 held grant beats ack
      {4'd12, 4'd5, 16'h0000, 8'h02, 1'b0, 16'h0004, 16'h8082}, // R12
      {4'd5,  4'd2, 16'h0001, 8'h02, 1'b0, 16'h0004, 16'h8082}, // R5
      {4'd5,  4'd1, 16'h00A0, 8'h02, 1'b0, 16'h0104, 16'h8082}, // R5 free 1
      {4'd5,  4'd1, 16'h00A0, 8'h02, 1'b0, 16'h0104, 16'h8082}, // R5 double free
      {4'd7,  4'd2, 16'h0003, 8'h02, 1'b0, 16'h0104, 16'h8082}, // R7
      {4'd7,  4'd1, 16'h00C0, 8'h02, 1'b0, 16'h0104, 16'h8003}, // R7 queue 3
      {4'd7,  4'd2, 16'h0000, 8'h02, 1'b0, 16'h0104, 16'h8003}, // R7
      {4'd7,  4'd1, 16'h00C0, 8'h02, 1'b0, 16'h0104, 16'h8003}, // R7 queue 0
      {4'd7,  4'd4, 16'h0000, 8'h02, 1'b0, 16'h0104, 16'h8000}, // R7 take
      {4'd8,  4'd4, 16'h0000, 8'h02, 1'b0, 16'h0104, 16'h8082}, // R8 empty again
      {4'd9,  4'd3, 16'h0002, 8'h02, 1'b0, 16'h0104, 16'h0282}, // R9 rx push
      {4'd9,  4'd3, 16'h0000, 8'h02, 1'b0, 16'h0104, 16'h0282}, // R9
      {4'd9,  4'd1, 16'h0080, 8'h02, 1'b0, 16'h0204, 16'h0082}, // R9 rx free
      {4'd11, 4'd1, 16'h0060, 8'h02, 1'b0, 16'h0204, 16'h0082}, // R11
      {4'd11, 4'd1, 16'h00E0, 8'h02, 1'b0, 16'h0204, 16'h0082}, // R11
      {4'd11, 4'd1, 16'h0000, 8'h02, 1'b0, 16'h0204, 16'h0082}, // R11
      {4'd9,  4'd1, 16'h0080, 8'h02, 1'b0, 16'h0304, 16'h8082}, // R9
      {4'd3,  4'd1, 16'h0020, 8'h00, 1'b1, 16'h0204, 16'h8080}, // R3 lowest
      {4'd3,  4'd1, 16'h0020, 8'h01, 1'b1, 16'h0104, 16'h8081}, // R3
      {4'd7,  4'd2, 16'h0003, 8'h01, 1'b1, 16'h0104, 16'h8081}, // R7
      {4'd7,  4'd1, 16'h00C0, 8'h01, 1'b1, 16'h0104, 16'h8003}, // R7
      {4'd9,  4'd3, 16'h0001, 8'h01, 1'b1, 16'h0104, 16'h0103}, // R9
      {4'd10, 4'd1, 16'h0040, 8'h00, 1'b0, 16'h0404, 16'h8080}  // R10
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_we = 1'b0;
   logic [15:0] cmd_word = '0;
   logic        pnum_we = 1'b0;
   logic [7:0]  pnum_wdata = '0;
   logic        int_ack = 1'b0;
   logic        rx_done_we = 1'b0;
   logic [7:0]  rx_done_num = '0;
   logic        tx_taken = 1'b0;
   logic [7:0]  alloc_result;
   logic        alloc_int;
   logic [15:0] mem_info;
   logic [15:0] fifo_status;

   int n_chk = 0;
   int n_bad = 0;

   always #10 clk = ~clk;

   pbm_mgr u_pbm_mgr (
      .clk, .rst_n, .cmd_we, .cmd_word, .pnum_we, .pnum_wdata, .int_ack,
      .rx_done_we, .rx_done_num, .tx_taken,
      .alloc_result, .alloc_int, .mem_info, .fifo_status
   );

   task automatic chk(input int req, input string what, input logic [15:0] act,
                      input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL R%0d %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic chk_all(input int req, input logic [7:0] res, input logic irq,
                          input logic [15:0] mem, input logic [15:0] fst);
      chk(req, "alloc_result", 16'(alloc_result), 16'(res));
      chk(req, "alloc_int", 16'(alloc_int), 16'(irq));
      chk(req, "mem_info", mem_info, mem);
      chk(req, "fifo_status", fifo_status, fst);
   endtask

   // Drive one operation for one clock, starting just after a falling edge
   task automatic do_op(input int op, input logic [15:0] arg);
      case (op)
         OP_CMD:  begin cmd_we = 1'b1; cmd_word = arg; end
         OP_PNUM: begin pnum_we = 1'b1; pnum_wdata = arg[7:0]; end
         OP_RXD:  begin rx_done_we = 1'b1; rx_done_num = arg[7:0]; end
         OP_TXP:  tx_taken = 1'b1;
         OP_ACK:  int_ack = 1'b1;
         default: ;
      endcase
      @(posedge clk);
      @(negedge clk);
      cmd_we = 1'b0; pnum_we = 1'b0; rx_done_we = 1'b0; tx_taken = 1'b0; int_ack = 1'b0;
   endtask

   task automatic idle();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic finish_run();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk_all(1, 8'h00, 1'b0, 16'h0404, 16'h8080); // R1 during reset
      rst_n = 1'b1;
      idle();
      chk_all(1, 8'h00, 1'b0, 16'h0404, 16'h8080); // R1 after release

      for (int i = 0; i < NV; i++) begin
         do_op(int'(VEC[i][60:57]), VEC[i][56:41]);
         chk_all(int'(VEC[i][64:61]), VEC[i][40:33], VEC[i][32], VEC[i][31:16], VEC[i][15:0]);
      end

      // R10: a held allocation is dropped by the manager reset command
      for (int i = 0; i < 4; i++) do_op(OP_CMD, 16'h0020);
      do_op(OP_CMD, 16'h0020);
      idle();
      idle();
      chk(6, "held alloc stays idle", 16'(alloc_int), 16'(1'b1)); // R6 flag left from grant 3
      do_op(OP_ACK, 16'h0);
      chk(6, "no completion while pool empty", 16'(alloc_int), 16'h0); // R6
      chk(6, "fail flag", 16'(alloc_result), 16'h0083); // R6
      do_op(OP_CMD, 16'h0040);
      idle();
      idle();
      chk_all(10, 8'h00, 1'b0, 16'h0404, 16'h8080); // R10 no late grant

      // R7: overfill the transmit queue, then drain in order
      for (int i = 0; i < 4; i++) begin
         do_op(OP_PNUM, 16'(i));
         do_op(OP_CMD, 16'h00C0);
      end
      do_op(OP_PNUM, 16'h0001);
      do_op(OP_CMD, 16'h00C0);
      for (int i = 0; i < 4; i++) begin
         chk(7, "tx head order", fifo_status, 16'h8000 | 16'(i));
         do_op(OP_TXP, 16'h0);
      end
      chk(7, "extra push dropped", fifo_status, 16'h8080);

      // R1: asynchronous reset in the middle of activity
      do_op(OP_CMD, 16'h0020);
      do_op(OP_RXD, 16'h0002);
      #3 rst_n = 1'b0;
      #3 chk_all(1, 8'h00, 1'b0, 16'h0404, 16'h8080);
      @(negedge clk);
      rst_n = 1'b1;
      idle();
      chk_all(1, 8'h00, 1'b0, 16'h0404, 16'h8080);

      finish_run();
   end

endmodule